// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Slave

This block gives an external processor read and write access to a small bank of internal 16-bit registers over a parallel bus. The bus has an active-low chip select, an active-low address strobe, a read/write line (high for read, low for write), an active-low data strobe, a 21-bit word address and a 16-bit data path. A static mode pin selects one of two strobe protocols. In synchronous mode the address strobe is a one-clock pulse that marks the start of an access. In asynchronous mode the address strobe and the data strobe are both held low for the whole access. The bus clock samples every input in both modes.

Addresses count 16-bit words. The slave's address bit 0 therefore maps to bit 1 of a byte-addressed host bus. Each register keeps its low byte at the lower byte address (little endian). The read data leaves the block on a separate output together with an output enable, which the pad ring uses to drive the shared data lines. A window of `NREGS` registers starting at `BASE_ADDR` is mapped. Any other address reads as zero and ignores writes.

Top module: `hbus_regslave`

## Requirements
- R1: After reset, `rdata_oe_o` is 0, `rdata_o` is 0 and every mapped register holds 0.
- R2: In synchronous mode (`sync_mode_i`=1), an access starts on the rising edge where `cs_n_i` and `as_n_i` are both low. For a read, `rdata_oe_o` and `rdata_o` become valid after the next rising edge. They stay valid while `cs_n_i` stays low, and `rdata_oe_o` falls after the first rising edge that samples `cs_n_i` high.
- R3: In synchronous mode, a write stores the `wdata_i` value sampled on the rising edge after the address-strobe edge.
- R4: In asynchronous mode (`sync_mode_i`=0), chip select, address strobe and data strobe each pass through a two-flop synchronizer. If all three fall before the same rising edge E0, read data and `rdata_oe_o` become valid after edge E3 and not before. `rdata_oe_o` falls after the third rising edge following the release of chip select.
- R5: In asynchronous mode, a write is committed exactly once, on the first clock where the synchronized chip select and data strobe are both low. A later change of `wdata_i` while the strobes stay low does not alter the stored value.
- R6: `rdata_oe_o` is asserted only for a read access with chip select low. It is never asserted during a write access.
- R7: A read of an address outside [`BASE_ADDR`, `BASE_ADDR`+`NREGS`) asserts `rdata_oe_o` with `rdata_o` = 0.
- R8: A write to an address outside the mapped window changes no register. This includes an address whose low bits equal a mapped index.
- R9: The address is captured at the start of the access. A change of `addr_i` after the synchronous address-strobe pulse does not change which register is accessed.
- R10: Accesses may follow each other with chip select high for a single sampled clock between them, in either mode, and each one completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; samples every bus input |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode_i | input | 1 | Static protocol select: 1 synchronous, 0 asynchronous |
| cs_n_i | input | 1 | Chip select, active low |
| as_n_i | input | 1 | Address strobe, active low |
| ds_n_i | input | 1 | Data strobe, active low, used in asynchronous mode only |
| rw_i | input | 1 | 1 read, 0 write |
| addr_i | input | 21 | Word address |
| wdata_i | input | 16 | Write data from the host |
| rdata_o | output | 16 | Read data towards the host |
| rdata_oe_o | output | 1 | Output enable for the read data drivers |

## Verification
A wrong controller state shows up on the enable output within one or two clocks. An enable that rises a cycle early or late, or that lingers after chip select rises, is caught at the exact sample the bench computes for each mode. A bad address capture or a bad register index appears as wrong data on the next read of the affected word. That read comes right away in the back-to-back sequences, and an aliasing unmapped write is followed by a read of the mapped word it could have hit. A write that is committed twice is exposed by changing the write data while the asynchronous strobes stay low and then reading the value back.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

  // Access controller states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // waiting for chip select and address strobe
    ST_ADDR = 2'd1,   // address captured, waiting for the data phase
    ST_HOLD = 2'd2    // data phase done, waiting for chip select release
  } hreg_state_e;

  // Depth of the strobe synchronizers used in asynchronous mode
  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/hreg_rst_sync.sv
// Reset conditioner: asserts asynchronously, releases on a clock edge.
module hreg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/hreg_sync.sv
// Multi-stage synchronizer for a small bundle of bus strobes.
module hreg_sync #(
  parameter int unsigned      WIDTH   = 3,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hreg_ctrl.sv
// Access controller: strobe conditioning per mode, address capture and
// generation of the one-shot write and read-load pulses.
module hreg_ctrl
  import hreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode_i,
  input  logic              cs_n_i,
  input  logic              as_n_i,
  input  logic              ds_n_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic              cap_rd_o,
  output logic              wr_en_o,
  output logic              rd_ld_o,
  output logic              oe_o
);

  localparam int unsigned NSTRB = 3;

  // Synchronized strobes: {cs, as, ds}
  logic [NSTRB-1:0] strb_s;

  hreg_sync #(
    .WIDTH  (NSTRB),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NSTRB{1'b1}})
  ) u_strb_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({cs_n_i, as_n_i, ds_n_i}),
    .q_o  (strb_s)
  );

  // Effective strobes: raw in synchronous mode, synchronized otherwise
  logic cs_eff;
  logic as_eff;
  logic ds_eff;

  always_comb begin
    if (sync_mode_i) begin
      cs_eff = cs_n_i;
      as_eff = as_n_i;
      ds_eff = 1'b0;      // data strobe not used: data phase is implicit
    end else begin
      cs_eff = strb_s[2];
      as_eff = strb_s[1];
      ds_eff = strb_s[0];
    end
  end

  hreg_state_e       state_q, state_d;
  logic              oe_q, oe_d;
  logic              cap_en;
  logic              wr_en;
  logic              rd_ld;
  logic [ADDR_W-1:0] cap_addr_q;
  logic              cap_rd_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    oe_d    = oe_q;
    cap_en  = 1'b0;
    wr_en   = 1'b0;
    rd_ld   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        oe_d = 1'b0;
        if (!cs_eff && !as_eff) begin
          cap_en  = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (cs_eff) begin
          state_d = ST_IDLE;
          oe_d    = 1'b0;
        end else if (!ds_eff) begin
          state_d = ST_HOLD;
          if (cap_rd_q) begin
            rd_ld = 1'b1;
            oe_d  = 1'b1;
          end else begin
            wr_en = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cs_eff) begin
          state_d = ST_IDLE;
          oe_d    = 1'b0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        oe_d    = 1'b0;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      oe_q    <= oe_d;
    end
  end

  // Captured access attributes, enabled only at access start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_rd_q   <= 1'b0;
    end else if (cap_en) begin
      cap_addr_q <= addr_i;
      cap_rd_q   <= rw_i;
    end
  end

  assign cap_addr_o = cap_addr_q;
  assign cap_rd_o   = cap_rd_q;
  assign wr_en_o    = wr_en;
  assign rd_ld_o    = rd_ld;
  assign oe_o       = oe_q;

endmodule

// File: rtl/hreg_regfile.sv
// Register bank with window decode; unmapped reads give zero.
module hreg_regfile #(
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NREGS     = 32,
  parameter int unsigned BASE_ADDR = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_ld_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              hit_o
);

  localparam int unsigned        IDX_W   = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam int unsigned        XW      = ADDR_W + 1;
  localparam logic [XW-1:0]      BASE_X  = XW'(BASE_ADDR);
  localparam logic [XW-1:0]      LIMIT_X = XW'(BASE_ADDR) + XW'(NREGS);

  logic [XW-1:0]    addr_x;
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign addr_x = {1'b0, addr_i};
  assign hit    = (addr_x >= BASE_X) && (addr_x < LIMIT_X);
  assign idx    = IDX_W'(addr_x - BASE_X);

  logic [NREGS-1:0][DATA_W-1:0] reg_vals;

  for (genvar g = 0; g < NREGS; g++) begin : gen_reg
    logic              sel;
    logic [DATA_W-1:0] val_q;

    assign sel = wr_en_i && hit && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (sel) begin
        val_q <= wdata_i;
      end
    end

    assign reg_vals[g] = val_q;
  end

  logic [DATA_W-1:0] rd_sel;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_sel = '0;
    if (hit) begin
      rd_sel = reg_vals[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_ld_i) begin
      rdata_q <= rd_sel;
    end
  end

  assign rdata_o = rdata_q;
  assign hit_o   = hit;

endmodule

// File: rtl/hbus_regslave.sv
// Dual-mode host register bus slave, top level.
module hbus_regslave #(
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NREGS     = 32,
  parameter int unsigned BASE_ADDR = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode_i,
  input  logic              cs_n_i,
  input  logic              as_n_i,
  input  logic              ds_n_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);

  logic              rst_n_int;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_rd;
  logic              wr_en;
  logic              rd_ld;
  logic              hit;

  hreg_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk    (clk),
    .rst_n_i(rst_n),
    .rst_n_o(rst_n_int)
  );

  hreg_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sync_mode_i(sync_mode_i),
    .cs_n_i     (cs_n_i),
    .as_n_i     (as_n_i),
    .ds_n_i     (ds_n_i),
    .rw_i       (rw_i),
    .addr_i     (addr_i),
    .cap_addr_o (cap_addr),
    .cap_rd_o   (cap_rd),
    .wr_en_o    (wr_en),
    .rd_ld_o    (rd_ld),
    .oe_o       (rdata_oe_o)
  );

  hreg_regfile #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NREGS    (NREGS),
    .BASE_ADDR(BASE_ADDR)
  ) u_regfile (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .addr_i (cap_addr),
    .wdata_i(wdata_i),
    .wr_en_i(wr_en),
    .rd_ld_i(rd_ld),
    .rdata_o(rdata_o),
    .hit_o  (hit)
  );

endmodule

// File: rtl/hbus_regslave_chk.sv
// Property checker attached to the slave top.
module hbus_regslave_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_mode_i,
  input logic              cs_n_i,
  input logic              rdata_oe_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              wr_en,
  input logic              rd_ld,
  input logic              cap_rd,
  input logic              hit
);

  // R2: a sampled high chip select in synchronous mode turns the enable off
  a_r2_oe_off_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode_i && cs_n_i) |=> !rdata_oe_o);

  // R2: loading read data is followed by an enabled output
  a_r2_oe_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ld |=> rdata_oe_o);

  // R6: the enable only accompanies a read access
  a_r6_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe_o |-> cap_rd);

  // R6: a single access never both writes and loads read data
  a_r6_wr_rd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_ld);

  // R5: a commit is a single-cycle event
  a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R7: unmapped reads present zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe_o && !hit) |-> (rdata_o == '0));

endmodule

bind hbus_regslave hbus_regslave_chk #(
  .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .sync_mode_i(sync_mode_i),
  .cs_n_i     (cs_n_i),
  .rdata_oe_o (rdata_oe_o),
  .rdata_o    (rdata_o),
  .wr_en      (wr_en),
  .rd_ld      (rd_ld),
  .cap_rd     (cap_rd),
  .hit        (hit)
);

// File: tb/hbus_regslave_bench.sv
`timescale 1ns/1ps
module hbus_regslave_bench;

  localparam int unsigned ADDR_W = 21;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned NREGS  = 32;
  localparam int unsigned BASE   = 'h100;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sync_mode;
  logic              cs_n, as_n, ds_n, rw;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] data;
    string             req;
  } exp_t;

  exp_t exp_q[$];
  int   pushed = 0;
  int   popped = 0;

  always #2.5 clk = ~clk;

  hbus_regslave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS), .BASE_ADDR(BASE)
  ) u_hbus_regslave (
    .clk(clk), .rst_n(rst_n), .sync_mode_i(sync_mode),
    .cs_n_i(cs_n), .as_n_i(as_n), .ds_n_i(ds_n), .rw_i(rw),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] wa(input int unsigned a);
    return ADDR_W'(a);
  endfunction

  // Monitor: on each rising output enable, compare against the scoreboard
  initial begin : monitor
    logic oe_prev;
    oe_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (oe && !oe_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected read enable", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          popped++;
          check(rdata == e.data, e.req, "read data", int'(rdata), int'(e.data));
        end
      end
      oe_prev = oe;
    end
  end

  task automatic idle_bus();
    cs_n = 1'b1; as_n = 1'b1; ds_n = 1'b1; rw = 1'b1;
  endtask

  // Synchronous read: address changed after the pulse (R9)
  task automatic sync_read(input int unsigned a, input logic [DATA_W-1:0] e,
                           input string req);
    @(negedge clk);
    cs_n = 1'b0; as_n = 1'b0; rw = 1'b1; addr = wa(a);
    exp_q.push_back('{e, req}); pushed++;
    @(negedge clk);
    as_n = 1'b1; addr = wa('h1ABCD);
    check(oe == 1'b0, "R2", "enable before data phase", int'(oe), 0);
    @(negedge clk);
    check(oe == 1'b1, "R2", "enable one clock after strobe", int'(oe), 1);
    cs_n = 1'b1;
    @(negedge clk);
    check(oe == 1'b0, "R2", "enable after chip select release", int'(oe), 0);
  endtask

  task automatic sync_write(input int unsigned a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cs_n = 1'b0; as_n = 1'b0; rw = 1'b0; addr = wa(a);
    @(negedge clk);
    as_n = 1'b1; addr = wa('h1ABCD); wdata = d;
    @(negedge clk);
    check(oe == 1'b0, "R6", "enable during sync write", int'(oe), 0);
    cs_n = 1'b1; rw = 1'b1;
  endtask

  task automatic async_read(input int unsigned a, input logic [DATA_W-1:0] e,
                            input string req);
    @(negedge clk);
    cs_n = 1'b0; as_n = 1'b0; ds_n = 1'b0; rw = 1'b1; addr = wa(a);
    exp_q.push_back('{e, req}); pushed++;
    repeat (3) @(negedge clk);
    check(oe == 1'b0, "R4", "enable before third edge", int'(oe), 0);
    @(negedge clk);
    check(oe == 1'b1, "R4", "enable after third edge", int'(oe), 1);
    cs_n = 1'b1; as_n = 1'b1; ds_n = 1'b1;
    repeat (3) @(negedge clk);
    check(oe == 1'b0, "R4", "enable after release", int'(oe), 0);
  endtask

  // Asynchronous write; data changes to d2 while strobes stay low (R5)
  task automatic async_write(input int unsigned a, input logic [DATA_W-1:0] d,
                             input logic [DATA_W-1:0] d2);
    @(negedge clk);
    cs_n = 1'b0; as_n = 1'b0; ds_n = 1'b0; rw = 1'b0; addr = wa(a); wdata = d;
    repeat (4) @(negedge clk);
    check(oe == 1'b0, "R6", "enable during async write", int'(oe), 0);
    wdata = d2;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; as_n = 1'b1; ds_n = 1'b1; rw = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; sync_mode = 1'b1; idle_bus();
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(oe == 1'b0, "R1", "enable after reset", int'(oe), 0);
    check(rdata == '0, "R1", "read data after reset", int'(rdata), 0);

    // Synchronous mode
    sync_read(BASE + 3, 16'h0000, "R1");
    sync_write(BASE + 3, 16'hA5A5);
    sync_read(BASE + 3, 16'hA5A5, "R3");
    sync_write(BASE + 0, 16'h1111);
    sync_write(BASE + NREGS - 1, 16'hFFFE);
    sync_read(BASE + 0, 16'h1111, "R10");
    sync_read(BASE + NREGS - 1, 16'hFFFE, "R10");
    sync_read(BASE + 3, 16'hA5A5, "R9");
    sync_write(BASE + NREGS + 3, 16'hDEAD);
    sync_read(BASE + 3, 16'hA5A5, "R8");
    sync_read(BASE + NREGS + 3, 16'h0000, "R7");
    sync_read(0, 16'h0000, "R7");

    // Asynchronous mode, switched while idle
    repeat (3) @(negedge clk);
    sync_mode = 1'b0;
    repeat (3) @(negedge clk);
    async_read(BASE + 3, 16'hA5A5, "R4");
    async_write(BASE + 7, 16'h1234, 16'h9999);
    async_read(BASE + 7, 16'h1234, "R5");
    async_read(BASE + 40, 16'h0000, "R7");
    async_write(BASE + NREGS + 7, 16'hBEEF, 16'hBEEF);
    async_read(BASE + 7, 16'h1234, "R8");
    async_read(BASE + 0, 16'h1111, "R10");
    async_read(BASE + NREGS - 1, 16'hFFFE, "R10");

    repeat (5) @(negedge clk);
    check(popped == pushed, "R6", "reads observed", popped, pushed);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule